// File: doc/BRIEF.md
# Predicated Vector Gather Load Engine

This block fills a vector of 32-bit words from memory, one word per lane, at addresses scattered by a per-lane index. A start pulse captures a 64-bit base address, a packed vector of 32-bit indices, a per-lane enable mask and an extension mode. For every enabled lane the engine forms the address as the base plus the index times four, issues a single-word read on a valid/ready request port and stores the returned word in that lane. Lanes whose enable bit is clear read as zero and never reach memory.

The engine works through the enabled lanes from lowest to highest and has at most one read in flight. A response flagged as an error ends the operation: the engine raises a fault flag together with the number of the offending lane and issues nothing further. Otherwise the completed vector is presented with a single-cycle done pulse. The lane count follows from the vector width parameter.

Top module: `gather_load_engine`

## Requirements
- R1: A lane's read address is base_addr plus four times the extended 64-bit index, computed modulo 2^64 with no overflow indication.
- R2: With sign_ext = 1 the 32-bit index is sign-extended to 64 bits; with sign_ext = 0 it is zero-extended.
- R3: A lane whose bit in lane_en is 0 issues no read and its 32-bit field of result reads as zero; lane n occupies result bits [32n+31:32n].
- R4: Reads are issued in ascending lane order, at most one outstanding; req_valid and req_addr stay unchanged until req_ready is seen.
- R5: Each successful response word is stored in its lane; after the last enabled lane's response, done is high for exactly one cycle with the full result on result. After reset done, fault, req_valid and busy are 0 and result is zero.
- R6: If lane_en is all zeros, done is high in the cycle after start is accepted, with result all zeros and no read issued.
- R7: A response with rsp_err = 1 raises fault with fault_lane equal to that lane, stops all further reads, gives no done pulse, and leaves previously loaded lanes with their data and later lanes at zero.
- R8: A disabled lane never raises fault, whatever address its index would produce.
- R9: A start pulse while busy is high is ignored; the running operation and its inputs are unaffected. A new accepted start clears fault.
- R10: The vector width parameter VLEN_BITS (128 to 2048) sets LANES = VLEN_BITS/32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a gather when idle |
| base_addr | input | 64 | Scalar base address |
| index_vec | input | LANES*32 | Per-lane 32-bit indices, lane 0 in the low bits |
| lane_en | input | LANES | Per-lane enable mask |
| sign_ext | input | 1 | 1: sign-extend indices, 0: zero-extend |
| req_valid | output | 1 | Read request valid |
| req_addr | output | 64 | Read byte address |
| req_ready | input | 1 | Memory accepts request |
| rsp_valid | input | 1 | Read response valid |
| rsp_data | input | 32 | Read response word |
| rsp_err | input | 1 | Read response error |
| result | output | LANES*32 | Gathered vector |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Operation ended on an error |
| fault_lane | output | $clog2(LANES) | Lane that faulted |
| busy | output | 1 | Operation in progress |

## Verification
The hardest case is a disabled lane whose index would produce an illegal address, because it must cause nothing at all. The bench's memory model treats any address with top byte 0xEE as an error, and one stimulus places a large zero-extended index in a lane so that only that lane lands there; running it once with the lane disabled and once enabled separates silent skipping from a fault with partial data. A second start is pulsed mid-operation under a randomly stalling memory to show it is ignored.

// File: rtl/gather_pkg.sv
package gather_pkg;
    typedef enum logic [1:0] {
        GS_IDLE = 2'd0,
        GS_REQ  = 2'd1,
        GS_WAIT = 2'd2
    } gather_st_e;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned ADDR_W = 64;
endpackage

// File: rtl/gather_addr_gen.sv
module gather_addr_gen
    import gather_pkg::*;
(
    input  logic [ADDR_W-1:0] base,
    input  logic [WORD_W-1:0] index,
    input  logic              sext,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] ext_idx;

    always_comb begin
        ext_idx = {{(ADDR_W-WORD_W){sext & index[WORD_W-1]}}, index};
        addr    = base + (ext_idx << 2);
    end
endmodule

// File: rtl/gather_lane_pick.sv
module gather_lane_pick #(
    parameter int unsigned LANES = 4,
    localparam int unsigned LW   = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic [LANES-1:0] mask,
    output logic             found,
    output logic [LW-1:0]    lane
);
    logic [LANES-1:0] below;
    logic [LANES-1:0] sel;

    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_chain
            if (g == 0) begin : g_first
                assign below[g] = 1'b0;
            end else begin : g_rest
                assign below[g] = below[g-1] | mask[g-1];
            end
            assign sel[g] = mask[g] & ~below[g];
        end
    endgenerate

    always_comb begin
        found = |mask;
        lane  = '0;
        for (int i = 0; i < LANES; i++) begin
            if (sel[i]) lane = lane | LW'(i);
        end
    end
endmodule

// File: rtl/gather_load_engine.sv
module gather_load_engine
    import gather_pkg::*;
#(
    parameter int unsigned VLEN_BITS = 128,
    localparam int unsigned LANES    = VLEN_BITS / WORD_W,
    localparam int unsigned LW       = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [ADDR_W-1:0]       base_addr,
    input  logic [LANES*WORD_W-1:0] index_vec,
    input  logic [LANES-1:0]        lane_en,
    input  logic                    sign_ext,
    output logic                    req_valid,
    output logic [ADDR_W-1:0]       req_addr,
    input  logic                    req_ready,
    input  logic                    rsp_valid,
    input  logic [WORD_W-1:0]       rsp_data,
    input  logic                    rsp_err,
    output logic [LANES*WORD_W-1:0] result,
    output logic                    done,
    output logic                    fault,
    output logic [LW-1:0]           fault_lane,
    output logic                    busy
);
    typedef struct packed {
        gather_st_e                   st;
        logic [ADDR_W-1:0]            base;
        logic [LANES-1:0][WORD_W-1:0] idx;
        logic [LANES-1:0]             en;
        logic [LANES-1:0]             pend;
        logic                         sext;
        logic [LANES-1:0][WORD_W-1:0] res;
        logic                         done;
        logic                         fault;
        logic [LW-1:0]                flane;
    } eng_state_t;

    eng_state_t s_d, s_q;

    logic          cur_found;
    logic [LW-1:0] cur_lane;
    logic [LANES-1:0] pend_clr;

    gather_lane_pick #(.LANES(LANES)) u_pick (
        .mask  (s_q.pend),
        .found (cur_found),
        .lane  (cur_lane)
    );

    gather_addr_gen u_agen (
        .base  (s_q.base),
        .index (s_q.idx[cur_lane]),
        .sext  (s_q.sext),
        .addr  (req_addr)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        pend_clr = s_q.pend;
        pend_clr[cur_lane] = 1'b0;

        case (s_q.st)
            GS_IDLE: begin
                if (start) begin
                    s_d.base  = base_addr;
                    s_d.idx   = index_vec;
                    s_d.en    = lane_en;
                    s_d.pend  = lane_en;
                    s_d.sext  = sign_ext;
                    s_d.res   = '0;
                    s_d.fault = 1'b0;
                    s_d.flane = '0;
                    if (lane_en == '0) begin
                        s_d.done = 1'b1;
                    end else begin
                        s_d.st = GS_REQ;
                    end
                end
            end
            GS_REQ: begin
                if (req_ready) s_d.st = GS_WAIT;
            end
            GS_WAIT: begin
                if (rsp_valid) begin
                    if (rsp_err) begin
                        s_d.fault = 1'b1;
                        s_d.flane = cur_lane;
                        s_d.pend  = '0;
                        s_d.st    = GS_IDLE;
                    end else begin
                        s_d.res[cur_lane] = rsp_data;
                        s_d.pend          = pend_clr;
                        if (pend_clr == '0) begin
                            s_d.done = 1'b1;
                            s_d.st   = GS_IDLE;
                        end else begin
                            s_d.st = GS_REQ;
                        end
                    end
                end
            end
            default: s_d.st = GS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign req_valid  = (s_q.st == GS_REQ) && cur_found;
    assign result     = s_q.res;
    assign done       = s_q.done;
    assign fault      = s_q.fault;
    assign fault_lane = s_q.flane;
    assign busy       = (s_q.st != GS_IDLE);

    // Request held until accepted (R4)
    p_addr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_addr));
    // Only one read in flight (R4)
    p_single_out_r4: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_valid);
    // Reads only for enabled lanes (R3)
    p_req_enabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> s_q.en[cur_lane]);
    // Done lasts a single cycle (R5)
    p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // A fault names an enabled lane (R8)
    p_fault_enabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault) |-> s_q.en[fault_lane]);
    // Faulted operation never completes (R7)
    p_no_done_fault_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> !done);
    // Faulted operation issues nothing more (R7)
    p_quiet_fault_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> !req_valid);
    // Start while busy leaves captured inputs alone (R9)
    p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy && start |=> $stable(s_q.en) && $stable(s_q.base));
endmodule

// File: tb/gather_load_engine_test.sv
module gather_load_engine_test;
    localparam int  CLK_PERIOD = 10;
    localparam int  VLEN       = 256;
    localparam int  LANES      = VLEN / 32;   // R10: 8 lanes from 256 bits
    localparam int  LW         = $clog2(LANES);

    typedef logic [LANES-1:0][31:0] vec_t;
    typedef struct {
        vec_t         res;
        logic         flt;
        logic [LW-1:0] fl;
    } exp_t;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               start = 1'b0;
    logic [63:0]        base_addr = '0;
    logic [LANES*32-1:0] index_vec = '0;
    logic [LANES-1:0]   lane_en = '0;
    logic               sign_ext = 1'b0;
    logic               req_valid;
    logic [63:0]        req_addr;
    logic               req_ready = 1'b0;
    logic               rsp_valid = 1'b0;
    logic [31:0]        rsp_data = '0;
    logic               rsp_err = 1'b0;
    logic [LANES*32-1:0] result;
    logic               done, fault, busy;
    logic [LW-1:0]      fault_lane;

    int checks = 0;
    int fails  = 0;
    logic [63:0] addr_q[$];
    exp_t        exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    gather_load_engine #(.VLEN_BITS(VLEN)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
        .index_vec(index_vec), .lane_en(lane_en), .sign_ext(sign_ext),
        .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_err(rsp_err),
        .result(result), .done(done), .fault(fault),
        .fault_lane(fault_lane), .busy(busy)
    );

    function automatic logic [31:0] mem_word(input logic [63:0] a);
        return a[31:0] ^ a[63:32] ^ 32'h5A5A_1234;
    endfunction

    function automatic logic bad_addr(input logic [63:0] a);
        return a[63:56] == 8'hEE;
    endfunction

    task automatic check(input bit ok, input string req, input logic [255:0] act,
                         input logic [255:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Memory model: random ready, one-cycle response after each handshake
    initial begin
        logic        hs = 1'b0;
        logic [63:0] a = '0;
        forever begin
            @(negedge clk);
            if (hs) begin
                hs = 1'b0;
                req_ready = 1'b0;
                rsp_valid = 1'b1;
                rsp_err   = bad_addr(a);
                rsp_data  = mem_word(a);
            end else begin
                rsp_valid = 1'b0;
                rsp_err   = 1'b0;
                req_ready = ($urandom_range(0, 2) != 0);
                if (req_valid && req_ready) begin
                    hs = 1'b1;
                    a  = req_addr;
                    if (addr_q.size() == 0) begin
                        check(1'b0, "R3 unexpected read", req_addr, 0);
                    end else begin
                        logic [63:0] e;
                        e = addr_q.pop_front();
                        check(req_addr == e, "R1/R2/R4 read address", req_addr, e);
                    end
                end
            end
        end
    end

    // Monitor: compare completions against the scoreboard
    initial begin
        logic fprev = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n && (done || (fault && !fprev))) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R5 unexpected completion", result, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(result == e.res, "R3/R5/R7 result vector", result, e.res);
                    check(fault == e.flt, "R7/R8 fault flag", fault, e.flt);
                    if (e.flt)
                        check(fault_lane == e.fl, "R7 fault lane", fault_lane, e.fl);
                end
            end
            fprev = fault;
        end
    end

    task automatic run_gather(input logic [63:0] b, input vec_t ix,
                              input logic [LANES-1:0] en, input logic sx,
                              input bit poke);
        exp_t e;
        int   cyc;
        e.res = '0; e.flt = 1'b0; e.fl = '0;
        for (int l = 0; l < LANES; l++) begin
            if (en[l] && !e.flt) begin
                logic [63:0] a;
                a = b + ((sx ? {{32{ix[l][31]}}, ix[l]} : {32'h0, ix[l]}) * 64'd4);
                addr_q.push_back(a);
                if (bad_addr(a)) begin
                    e.flt = 1'b1;
                    e.fl  = LW'(l);
                end else begin
                    e.res[l] = mem_word(a);
                end
            end
        end
        exp_q.push_back(e);
        @(negedge clk);
        base_addr = b; index_vec = ix; lane_en = en; sign_ext = sx; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        base_addr = ~b; index_vec = '1; lane_en = '1; sign_ext = ~sx;
        if (poke) begin
            @(negedge clk);
            @(negedge clk);
            check(busy == 1'b1, "R9 busy during operation", busy, 1);
            start = 1'b1;  // R9: ignored second start
            @(negedge clk);
            start = 1'b0;
        end
        cyc = 0;
        while (!(done || fault)) begin
            @(negedge clk);
            cyc++;
        end
        if (en == '0)
            check(cyc == 0, "R6 done one cycle after start", cyc, 0);
        check(addr_q.size() == 0, "R4 all expected reads issued", addr_q.size(), 0);
        @(negedge clk);
        if (!e.flt) check(done == 1'b0, "R5 done single cycle", done, 0);
        else        check(req_valid == 1'b0 && done == 1'b0, "R7 halted after fault",
                          {req_valid, done}, 0);
        addr_q.delete();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        vec_t v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check({done, fault, req_valid, busy} == 4'b0, "R5 reset outputs",
              {done, fault, req_valid, busy}, 0);
        check(result == '0, "R5 reset result", result, 0);

        // R1 R5: all lanes, zero-extended
        for (int l = 0; l < LANES; l++) v[l] = 32'(l * 3);
        run_gather(64'h1000, v, '1, 1'b0, 1'b0);

        // R2: negative indices, sign then zero extension
        for (int l = 0; l < LANES; l++) v[l] = 32'hFFFF_FFF0 + 32'(l);
        run_gather(64'h0001_0000, v, '1, 1'b1, 1'b0);
        run_gather(64'h0001_0000, v, '1, 1'b0, 1'b0);

        // R3 R4: sparse enables
        for (int l = 0; l < LANES; l++) v[l] = 32'(100 - l * 7);
        run_gather(64'h2000, v, 8'b1010_0110, 1'b0, 1'b0);

        // R6: nothing enabled
        run_gather(64'h3000, v, '0, 1'b1, 1'b0);

        // R1: wrap below zero
        v = '0; v[0] = 32'hFFFF_FFFC; v[1] = 32'h1;
        run_gather(64'h8, v, 8'b0000_0011, 1'b1, 1'b0);

        // R8: disabled lane with illegal address
        for (int l = 0; l < LANES; l++) v[l] = 32'(l);
        v[3] = 32'hFFFF_FFFF;
        run_gather(64'hEDFF_FFFF_0000_0000, v, 8'b1111_0111, 1'b0, 1'b0);

        // R7: same lane enabled faults
        run_gather(64'hEDFF_FFFF_0000_0000, v, '1, 1'b0, 1'b0);

        // R9: start while busy ignored, fault cleared by new start
        for (int l = 0; l < LANES; l++) v[l] = 32'(l * 11);
        run_gather(64'h4000, v, '1, 1'b0, 1'b1);
        check(fault == 1'b0, "R9 fault cleared by new start", fault, 0);

        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule